// File: doc/BRIEF.md
# Waveform Sample Capture and Serial Readout

This block watches three per-phase sample streams that all advance on a shared base-rate strobe. It takes samples from one chosen phase at a selectable fraction of the base rate and keeps the newest one in a 24-bit holding register. A host learns that a fresh sample exists through an active-low interrupt. It then fetches the value through a byte-oriented serial port: an address byte is clocked in, and three data bytes come back, most significant byte first. The block only observes the streams. It has no back-pressure path, so the upstream calculations never stall.

An 8-bit mode word sets the behaviour. Bits [2:0] select the source, and only code 000 (current waveform) leads to capture. Bits [4:3] select the phase. Bits [6:5] set the decimation. Bit 7 is unused. Every write to the mode word restarts the decimation count. The first base strobe after a write is therefore always a capture point.

The serial port idles with the clock low. The host places each address bit on the data input and raises the clock, and the block samples the bit on that rising edge. Once the eighth address bit has been taken, the falling clock edge freezes a copy of the holding register. Bit 23 of that copy appears on the data output. Each later falling edge advances the output by one bit.

Top module: `wfc_top`

## Requirements
- R1: A capture happens only while mode bits [2:0] equal 000. Any other source code leaves the holding register and the interrupt untouched.
- R2: Mode bits [4:3] pick the phase that is captured: 00 takes stream A, 01 takes stream B, 10 takes stream C.
- R3: Mode bits [6:5] set the capture interval. Codes 00, 01, 10 and 11 capture on every 1st, 2nd, 4th or 8th base strobe. The first strobe after any mode write is a capture point.
- R4: With the mask input high, a capture drives `irq_n` low on the clock edge that latches the sample. With the mask low, a capture leaves `irq_n` high.
- R5: Once low, `irq_n` stays low until a one-cycle `stat_rd` pulse, which returns it high on the next edge. A capture in the same cycle as `stat_rd` keeps it low.
- R6: A read starts with address byte 0x12, sent MSB first and sampled on rising `spi_sck`. After it, the 24-bit held sample appears on `spi_miso` MSB first, updated after each falling edge, ready for the host to sample on the next rising edge.
- R7: The value sent is the one held when the address byte completed. Captures during the transfer do not change the bits sent.
- R8: Phase code 11 is reserved: strobes cause no capture and no interrupt.
- R9: After reset, the held sample is 0, `irq_n` is high, `spi_miso` is low, and the mode word is 0x00.
- R10: If the address byte is anything other than 0x12, `spi_miso` stays low for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Base-rate sample strobe, one cycle |
| ph_a | input | 24 | Phase A sample, two's complement |
| ph_b | input | 24 | Phase B sample, two's complement |
| ph_c | input | 24 | Phase C sample, two's complement |
| mode_wr | input | 1 | Mode word write strobe |
| mode_data | input | 8 | Mode word: [2:0] source, [4:3] phase, [6:5] rate |
| irq_mask | input | 1 | Sample-ready interrupt enable |
| stat_rd | input | 1 | Status read pulse, clears the interrupt |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data in |
| irq_n | output | 1 | Active-low interrupt |
| spi_miso | output | 1 | Serial data out |

## Verification
Each stream carries a distinct value at every strobe, so a readback shows which phase and which strobe supplied the held sample. Sweeping all four rate codes with the interrupt checked after every strobe separates the capture intervals from one another. Writing the mode word in the middle of a count shows whether the count restarts. Non-zero source codes and the reserved phase are tried to show that nothing is captured. A capture placed in the middle of a transfer, and a read at a wrong address, separate the snapshot behaviour from live shifting.

// File: rtl/wfc_pkg.sv
package wfc_pkg;

    localparam int SMP_W   = 24;
    localparam int ADDR_W  = 8;
    localparam int RATE_W  = 2;
    localparam int CNT_W   = 3;
    localparam int NPHASE  = 3;
    localparam logic [ADDR_W-1:0] RD_ADDR = 8'h12;

    typedef enum logic [1:0] {
        PH_A    = 2'b00,
        PH_B    = 2'b01,
        PH_C    = 2'b10,
        PH_NONE = 2'b11
    } phase_e;

    typedef struct packed {
        logic              spare;
        logic [RATE_W-1:0] rate;
        phase_e            phase;
        logic [2:0]        src;
    } mode_t;

    function automatic logic capture_enabled(mode_t m);
        return (m.src == 3'b000) && (m.phase != PH_NONE);
    endfunction

    function automatic logic [CNT_W-1:0] last_count(logic [RATE_W-1:0] r);
        logic [CNT_W:0] span;
        span = ({{CNT_W{1'b0}}, 1'b1} << r);
        return CNT_W'(span - 1'b1);
    endfunction

endpackage

// File: rtl/wfc_decim.sv
module wfc_decim
    import wfc_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          stb,
    input  logic [RW-1:0] rate,
    output logic          tick
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit = last_count(rate);
    assign tick  = stb && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (stb) begin
            if (cnt >= limit) cnt <= '0;
            else              cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wfc_capture.sv
module wfc_capture
    import wfc_pkg::*;
#(
    parameter int W  = SMP_W,
    parameter int NP = NPHASE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  mode_t        mode,
    input  logic [W-1:0] smp [NP],
    input  logic         irq_mask,
    input  logic         stat_rd,
    output logic [W-1:0] wf,
    output logic         cap,
    output logic         irq_n
);
    logic [W-1:0] sel;
    logic         irq_flag;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NP; i++) begin
            if (int'(mode.phase) == i) sel = smp[i];
        end
    end

    assign cap = tick && capture_enabled(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            wf <= '0;
        end else if (cap) begin
            wf <= sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_flag <= 1'b0;
        end else if (cap && irq_mask) begin
            irq_flag <= 1'b1;
        end else if (stat_rd) begin
            irq_flag <= 1'b0;
        end
    end

    assign irq_n = ~irq_flag;
endmodule

// File: rtl/wfc_spi.sv
module wfc_spi
    import wfc_pkg::*;
#(
    parameter int W  = SMP_W,
    parameter int AW = ADDR_W,
    parameter logic [AW-1:0] MATCH = RD_ADDR
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic         sck,
    input  logic         mosi,
    input  logic [W-1:0] wf,
    output logic         miso
);
    localparam int BC_W = $clog2(AW + W + 1) + 1;
    localparam logic [BC_W-1:0] BC_MAX = {BC_W{1'b1}};
    localparam logic [BC_W-1:0] AW_C   = BC_W'(AW);

    logic [2:0]      sck_s;
    logic [1:0]      cs_s;
    logic [1:0]      mosi_s;
    logic            rise, fall, active;
    logic [BC_W-1:0] bit_cnt;
    logic [AW-1:0]   addr;
    logic [W-1:0]    shreg;
    logic            xfer;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_s  <= '0;
            cs_s   <= '1;
            mosi_s <= '0;
        end else begin
            sck_s  <= {sck_s[1:0], sck};
            cs_s   <= {cs_s[0], cs_n};
            mosi_s <= {mosi_s[0], mosi};
        end
    end

    assign rise   = sck_s[1] & ~sck_s[2];
    assign fall   = ~sck_s[1] & sck_s[2];
    assign active = ~cs_s[1];

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            bit_cnt <= '0;
            addr    <= '0;
            shreg   <= '0;
            xfer    <= 1'b0;
        end else begin
            if (rise) begin
                if (bit_cnt < AW_C) addr <= {addr[AW-2:0], mosi_s[1]};
                if (bit_cnt != BC_MAX) bit_cnt <= bit_cnt + 1'b1;
            end
            if (fall) begin
                if (bit_cnt == AW_C && addr == MATCH) begin
                    shreg <= wf;
                    xfer  <= 1'b1;
                end else if (xfer && bit_cnt > AW_C) begin
                    shreg <= {shreg[W-2:0], 1'b0};
                end
            end
        end
    end

    assign miso = xfer & shreg[W-1];
endmodule

// File: rtl/wfc_top.sv
module wfc_top
    import wfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_stb,
    input  logic [SMP_W-1:0] ph_a,
    input  logic [SMP_W-1:0] ph_b,
    input  logic [SMP_W-1:0] ph_c,
    input  logic             mode_wr,
    input  logic [7:0]       mode_data,
    input  logic             irq_mask,
    input  logic             stat_rd,
    input  logic             spi_cs_n,
    input  logic             spi_sck,
    input  logic             spi_mosi,
    output logic             irq_n,
    output logic             spi_miso
);
    mode_t            mode;
    logic             tick;
    logic             cap;
    logic [SMP_W-1:0] wf;
    logic [SMP_W-1:0] smp [NPHASE];

    assign smp[0] = ph_a;
    assign smp[1] = ph_b;
    assign smp[2] = ph_c;

    always_ff @(posedge clk) begin
        if (rst)          mode <= '0;
        else if (mode_wr) mode <= mode_t'(mode_data);
    end

    wfc_decim u_decim (
        .clk     (clk),
        .rst     (rst),
        .restart (mode_wr),
        .stb     (smp_stb),
        .rate    (mode.rate),
        .tick    (tick)
    );

    wfc_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mode     (mode),
        .smp      (smp),
        .irq_mask (irq_mask),
        .stat_rd  (stat_rd),
        .wf       (wf),
        .cap      (cap),
        .irq_n    (irq_n)
    );

    wfc_spi u_spi (
        .clk  (clk),
        .rst  (rst),
        .cs_n (spi_cs_n),
        .sck  (spi_sck),
        .mosi (spi_mosi),
        .wf   (wf),
        .miso (spi_miso)
    );
endmodule

// File: rtl/wfc_checker.sv
module wfc_checker
    import wfc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input mode_t            mode,
    input logic             cap,
    input logic [SMP_W-1:0] wf,
    input logic             irq_n,
    input logic             irq_mask,
    input logic             stat_rd
);
    // R1: capture only for source code 000
    p_src_gate_r1: assert property (@(posedge clk) disable iff (rst)
        cap |-> (mode.src == 3'b000));

    // R8: reserved phase never captures
    p_reserved_phase_r8: assert property (@(posedge clk) disable iff (rst)
        cap |-> (mode.phase != PH_NONE));

    // R8: held sample changes only on a capture
    p_wf_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(wf));

    // R4: interrupt falls only after a masked-in capture
    p_irq_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> ($past(cap) && $past(irq_mask)));

    // R4: a capture with the mask set drives the interrupt low
    p_irq_set_r4: assert property (@(posedge clk) disable iff (rst)
        (cap && irq_mask) |=> !irq_n);

    // R5: interrupt held low until a status read
    p_irq_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !stat_rd) |=> !irq_n);

    // R5: status read without a new capture releases the interrupt
    p_irq_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !(cap && irq_mask)) |=> irq_n);
endmodule

bind wfc_top wfc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .cap      (cap),
    .wf       (wf),
    .irq_n    (irq_n),
    .irq_mask (irq_mask),
    .stat_rd  (stat_rd)
);

// File: tb/sim_wfc_top.sv
`timescale 1ns/1ps
module sim_wfc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_stb = 1'b0;
    logic [23:0] ph_a = '0, ph_b = '0, ph_c = '0;
    logic        mode_wr = 1'b0;
    logic [7:0]  mode_data = '0;
    logic        irq_mask = 1'b0;
    logic        stat_rd = 1'b0;
    logic        spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic        irq_n, spi_miso;

    always #2.5 clk = ~clk;

    wfc_top u0 (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [23:0] m_wf  = '0;
    logic [7:0]  m_mode = '0;
    int          m_cnt = 0;
    bit          m_irq = 0;

    // scoreboard
    logic [23:0] exp_q [$];
    string       tag_q [$];
    logic [23:0] got_q [$];

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (got_q.size() > 0 && exp_q.size() > 0) begin
            check(tag_q.pop_front(), {8'h0, got_q.pop_front()}, {8'h0, exp_q.pop_front()});
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mode(logic [7:0] v);
        @(negedge clk);
        mode_wr = 1'b1; mode_data = v;
        @(negedge clk);
        mode_wr = 1'b0;
        m_mode = v; m_cnt = 0;
    endtask

    task automatic clear_irq();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        m_irq = 0;
    endtask

    // one base strobe; checks interrupt against the model, then clears it
    task automatic strobe(string tag, logic [23:0] a, logic [23:0] b, logic [23:0] c, bit do_clear);
        int div;
        bit take;
        @(negedge clk);
        ph_a = a; ph_b = b; ph_c = c; smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        div  = 1 << m_mode[6:5];
        take = (m_mode[2:0] == 3'b000) && (m_mode[4:3] != 2'b11) && (m_cnt == 0);
        if (take) begin
            case (m_mode[4:3])
                2'b00:   m_wf = a;
                2'b01:   m_wf = b;
                default: m_wf = c;
            endcase
            if (irq_mask) m_irq = 1;
        end
        m_cnt = (m_cnt + 1) % div;
        wait_clk(1);
        check(tag, {31'h0, irq_n}, {31'h0, ~m_irq});
        if (do_clear && m_irq) begin
            clear_irq();
            wait_clk(1);
            check("R5 clear", {31'h0, irq_n}, 32'h1);
        end
    endtask

    task automatic spi_bit_out(logic b);
        spi_mosi = b;
        wait_clk(8);
        spi_sck = 1'b1;
        wait_clk(8);
        spi_sck = 1'b0;
    endtask

    // read transfer; inject_at >= 0 places a capture before that data bit
    task automatic spi_read(string tag, logic [7:0] addr, int inject_at);
        logic [23:0] word;
        logic [23:0] expv;
        word = '0;
        expv = (addr == 8'h12) ? m_wf : 24'h0;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        spi_cs_n = 1'b0;
        wait_clk(8);
        for (int i = 7; i >= 0; i--) spi_bit_out(addr[i]);
        for (int i = 0; i < 24; i++) begin
            if (i == inject_at) strobe("R7 capture mid-read", 24'h0F0F0F, 24'h1, 24'h2, 1'b1);
            wait_clk(8);
            word = {word[22:0], spi_miso};
            spi_sck = 1'b1;
            wait_clk(8);
            spi_sck = 1'b0;
        end
        wait_clk(8);
        spi_cs_n = 1'b1;
        wait_clk(8);
        got_q.push_back(word);
        wait_clk(2);
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // R9 reset state
        check("R9 irq_n after reset", {31'h0, irq_n}, 32'h1);
        check("R9 miso after reset", {31'h0, spi_miso}, 32'h0);
        spi_read("R9 held sample after reset", 8'h12, -1);

        // R2 default mode captures phase A, mask low keeps irq high (R4)
        strobe("R4 mask low no irq", 24'h123456, 24'hABCDEF, 24'h800001, 1'b1);
        spi_read("R2 phase A / R6 readout", 8'h12, -1);

        // R4 / R5 with mask high
        irq_mask = 1'b1;
        strobe("R4 mask high irq low", 24'hA5A5A5, 24'h5A5A5A, 24'h3C3C3C, 1'b0);
        wait_clk(10);
        check("R5 irq held low", {31'h0, irq_n}, 32'h0);
        clear_irq();
        wait_clk(1);
        check("R5 irq released", {31'h0, irq_n}, 32'h1);

        // R2 phases B and C
        write_mode(8'b0_00_01_000);
        strobe("R2 phase B irq", 24'h111111, 24'h222222, 24'h333333, 1'b1);
        spi_read("R2 phase B", 8'h12, -1);
        write_mode(8'b0_00_10_000);
        strobe("R2 phase C irq", 24'h444444, 24'h555555, 24'hD7AE14, 1'b1);
        spi_read("R2 phase C", 8'h12, -1);

        // R3 rate sweep
        for (int r = 0; r < 4; r++) begin
            write_mode({1'b0, 2'(r), 2'b00, 3'b000});
            for (int k = 0; k < 10; k++)
                strobe("R3 rate interval irq", 24'(32'h100 * (r + 1) + k), 24'h0, 24'h0, 1'b1);
            spi_read("R3 rate held value", 8'h12, -1);
        end

        // R3 restart on mode write mid-count
        write_mode(8'b0_11_00_000);
        strobe("R3 first after write", 24'h0AAAA0, 24'h0, 24'h0, 1'b1);
        strobe("R3 mid count", 24'h0BBBB0, 24'h0, 24'h0, 1'b1);
        strobe("R3 mid count", 24'h0CCCC0, 24'h0, 24'h0, 1'b1);
        write_mode(8'b0_11_00_000);
        strobe("R3 restart captures", 24'h0DDDD0, 24'h0, 24'h0, 1'b1);
        spi_read("R3 restart value", 8'h12, -1);

        // R1 non-zero source codes
        for (int s = 1; s < 8; s += 3) begin
            write_mode({5'b0, 3'(s)});
            strobe("R1 other source no irq", 24'hEEEEEE, 24'hEEEEEE, 24'hEEEEEE, 1'b1);
        end
        spi_read("R1 other source unchanged", 8'h12, -1);

        // R8 reserved phase
        write_mode(8'b0_00_11_000);
        strobe("R8 reserved phase no irq", 24'h777777, 24'h777777, 24'h777777, 1'b1);
        strobe("R8 reserved phase no irq", 24'h666666, 24'h666666, 24'h666666, 1'b1);
        spi_read("R8 reserved phase unchanged", 8'h12, -1);

        // R7 capture during a transfer
        write_mode(8'b0_00_00_000);
        strobe("R7 pre-load irq", 24'h2851EC, 24'h0, 24'h0, 1'b1);
        spi_read("R7 snapshot kept", 8'h12, 5);
        spi_read("R7 new value next read", 8'h12, -1);

        // R10 wrong address
        spi_read("R10 wrong address", 8'h13, -1);
        spi_read("R10 wrong address", 8'h92, -1);

        wait_clk(4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule